// File: doc/BRIEF.md
# Paged Memory Bank Select Latch

This block sits between an 8-bit microprocessor bus and one memory board that holds several 64K banks. Software picks the active bank by writing a page number to I/O port 0xFF. Each board is told by static configuration inputs which page it answers to. It raises its chip enable only when that page is the selected one, a memory cycle is in progress and the shared RAM-disable line is released. Beside the chip enable it drives the bank address bits that choose the 64K bank inside the array.

Reset clears the page register, so the board stays silent until software has written the port at least once. An optional common window at the top of the address space can be enabled, 4K or 8K in size. Accesses that fall inside it always resolve to page 0, whatever page is selected. With the window switched off, a page change swaps the whole 64K. A further configuration input turns paging off. The board then answers as a fixed bank and takes no notice of the port.

Top module: `pgbank_sel`

## Requirements
- R1: After reset, with paging on, `board_ce` stays low for every address until a page has been written to the port.
- R2: A write with `iorq_n` and `wr_n` both low and `cpu_addr[7:0]` equal to 0xFF, taken at a rising clock edge, loads `cpu_data[1:0]` as the page number and ignores `cpu_data[7:2]`; the new page takes effect for accesses after that edge.
- R3: An I/O write to any other low address byte, or a write with `iorq_n` high, leaves the page unchanged.
- R4: With paging on and outside an enabled common window, `bank_addr` equals the selected page. `board_ce` is high exactly when `mreq_n` is low, a page has been written, the selected page equals `cfg_board_page` and `ram_dis_n` is high.
- R5: `ram_dis_n` low forces `board_ce` low in every mode.
- R6: With `cfg_common_en` high and `cfg_common_8k` low, addresses 0xF000 to 0xFFFF resolve to page 0: `bank_addr` is 0, and `board_ce` follows R4 with page 0 in place of the selected page. Address 0xEFFF still uses the selected page.
- R7: With `cfg_common_en` high and `cfg_common_8k` high, the page-0 override of R6 covers 0xE000 to 0xFFFF. Address 0xDFFF still uses the selected page.
- R8: With `cfg_common_en` low, top-of-memory addresses use the selected page like any other address.
- R9: With `cfg_paging_en` low, `bank_addr` equals `cfg_board_page` and `board_ce` is high exactly when `mreq_n` is low and `ram_dis_n` is high. Port writes made in this mode do not change the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; clears the page register |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, sampled on port writes |
| iorq_n | input | 1 | Active-low I/O request |
| mreq_n | input | 1 | Active-low memory request |
| wr_n | input | 1 | Active-low write strobe |
| ram_dis_n | input | 1 | Active-low RAM-disable bus line; high when undriven |
| cfg_board_page | input | 2 | Page number this board answers to |
| cfg_paging_en | input | 1 | 1: paged operation; 0: fixed bank |
| cfg_common_en | input | 1 | 1: common window at top of memory exists |
| cfg_common_8k | input | 1 | Common window size: 0 = 4K, 1 = 8K |
| board_ce | output | 1 | Board select / chip enable, active high |
| bank_addr | output | 2 | Bank address bits to the memory array |

## Verification
The hardest case to reach from the ports is a port write made while paging is off. It has no visible effect in that mode, so the bench writes page 3 with paging off and then turns paging back on. An access must then still land on the page written before, which shows that the register was never loaded. The common-window edges also need care. The bench keeps a page other than 0 selected and probes each window's lowest address against the address just below it, with the board page set first to the selected page and then to 0.

// File: rtl/pgbank_pkg.sv
package pgbank_pkg;

   // Common window size selector
   typedef enum logic {
      WIN_SMALL = 1'b0,
      WIN_LARGE = 1'b1
   } win_size_e;

   // Number of bits needed to address a window of the given kilobytes
   function automatic int unsigned win_lsb(input int unsigned kbytes);
      return $clog2(kbytes * 1024);
   endfunction

endpackage

// File: rtl/pgbank_port_dec.sv
module pgbank_port_dec #(
   parameter int unsigned IO_ADDR_W = 8,
   parameter logic [IO_ADDR_W-1:0] PORT_ADDR = '1
) (
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic                 iorq_n,
   input  logic                 wr_n,
   input  logic                 accept,
   output logic                 wr_hit
);

   logic addr_match;

   assign addr_match = (io_addr == PORT_ADDR);
   assign wr_hit     = accept & addr_match & ~iorq_n & ~wr_n;

endmodule

// File: rtl/pgbank_page_reg.sv
module pgbank_page_reg #(
   parameter int unsigned PAGE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [PAGE_W-1:0] wr_page,
   output logic [PAGE_W-1:0] page_q,
   output logic              valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q  <= '0;
         valid_q <= 1'b0;
      end else if (wr_hit) begin
         page_q  <= wr_page;
         valid_q <= 1'b1;
      end
   end

endmodule

// File: rtl/pgbank_window.sv
module pgbank_window
   import pgbank_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned SMALL_KB   = 4,
   parameter int unsigned LARGE_KB   = 8,
   parameter bit          HAS_COMMON = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              win_en,
   input  win_size_e         win_size,
   output logic              in_common
);

   localparam int unsigned SMALL_LSB = win_lsb(SMALL_KB);
   localparam int unsigned LARGE_LSB = win_lsb(LARGE_KB);
   localparam int unsigned LOW_LSB   = (SMALL_LSB < LARGE_LSB) ? SMALL_LSB : LARGE_LSB;

   generate
      if (HAS_COMMON) begin : g_window
         logic hit_small;
         logic hit_large;
         logic unused_lo;

         assign hit_small = &addr[ADDR_W-1:SMALL_LSB];
         assign hit_large = &addr[ADDR_W-1:LARGE_LSB];
         assign unused_lo = ^addr[LOW_LSB-1:0];

         always_comb begin
            in_common = 1'b0;
            if (win_en) begin
               unique case (win_size)
                  WIN_SMALL: in_common = hit_small;
                  WIN_LARGE: in_common = hit_large;
                  default:   in_common = 1'b0;
               endcase
            end
         end
      end else begin : g_no_window
         logic unused_all;
         assign unused_all = ^{addr, win_en, win_size};
         assign in_common  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pgbank_sel.sv
module pgbank_sel
   import pgbank_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_W     = 2,
   parameter int unsigned IO_ADDR_W  = 8,
   parameter logic [IO_ADDR_W-1:0] PORT_ADDR = 8'hFF,
   parameter int unsigned SMALL_KB   = 4,
   parameter int unsigned LARGE_KB   = 8,
   parameter bit          HAS_COMMON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              iorq_n,
   input  logic              mreq_n,
   input  logic              wr_n,
   input  logic              ram_dis_n,
   input  logic [PAGE_W-1:0] cfg_board_page,
   input  logic              cfg_paging_en,
   input  logic              cfg_common_en,
   input  logic              cfg_common_8k,
   output logic              board_ce,
   output logic [PAGE_W-1:0] bank_addr
);

   localparam int unsigned COMMON_PAGE = 0;

   // Elaboration-time parameter checks
   generate
      if (PAGE_W < 1 || PAGE_W > DATA_W) begin : g_bad_page_w
         $error("pgbank_sel: PAGE_W must lie between 1 and DATA_W");
      end
      if (IO_ADDR_W > ADDR_W) begin : g_bad_io_w
         $error("pgbank_sel: IO_ADDR_W wider than ADDR_W");
      end
      if (HAS_COMMON && (win_lsb(SMALL_KB) >= ADDR_W || win_lsb(LARGE_KB) >= ADDR_W)) begin : g_bad_win
         $error("pgbank_sel: common window as large as the address space");
      end
   endgenerate

   logic              wr_hit;
   logic [PAGE_W-1:0] page_q;
   logic              valid_q;
   logic              in_common;
   logic [PAGE_W-1:0] eff_page;
   logic              mem_cycle;
   logic              unused_bits;

   assign unused_bits = ^{cpu_data[DATA_W-1:PAGE_W], cpu_addr};

   pgbank_port_dec #(
      .IO_ADDR_W (IO_ADDR_W),
      .PORT_ADDR (PORT_ADDR)
   ) u_dec (
      .io_addr (cpu_addr[IO_ADDR_W-1:0]),
      .iorq_n  (iorq_n),
      .wr_n    (wr_n),
      .accept  (cfg_paging_en),
      .wr_hit  (wr_hit)
   );

   pgbank_page_reg #(
      .PAGE_W (PAGE_W)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .wr_page (cpu_data[PAGE_W-1:0]),
      .page_q  (page_q),
      .valid_q (valid_q)
   );

   pgbank_window #(
      .ADDR_W     (ADDR_W),
      .SMALL_KB   (SMALL_KB),
      .LARGE_KB   (LARGE_KB),
      .HAS_COMMON (HAS_COMMON)
   ) u_win (
      .addr      (cpu_addr),
      .win_en    (cfg_common_en),
      .win_size  (cfg_common_8k ? WIN_LARGE : WIN_SMALL),
      .in_common (in_common)
   );

   assign mem_cycle = ~mreq_n & ram_dis_n;

   always_comb begin
      if (!cfg_paging_en) begin
         eff_page = cfg_board_page;
         board_ce = mem_cycle;
      end else begin
         eff_page = in_common ? PAGE_W'(COMMON_PAGE) : page_q;
         board_ce = mem_cycle & valid_q & (eff_page == cfg_board_page);
      end
   end

   assign bank_addr = eff_page;

endmodule

// File: rtl/pgbank_sel_chk.sv
module pgbank_sel_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PAGE_W    = 2,
   parameter int unsigned IO_ADDR_W = 8,
   parameter logic [IO_ADDR_W-1:0] PORT_ADDR = 8'hFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_data,
   input logic              iorq_n,
   input logic              wr_n,
   input logic              ram_dis_n,
   input logic [PAGE_W-1:0] cfg_board_page,
   input logic              cfg_paging_en,
   input logic              cfg_common_en,
   input logic              board_ce,
   input logic [PAGE_W-1:0] bank_addr
);

   logic port_wr;
   logic seen_wr;

   assign port_wr = cfg_paging_en & ~iorq_n & ~wr_n &
                    (cpu_addr[IO_ADDR_W-1:0] == PORT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_wr <= 1'b0;
      else if (port_wr) seen_wr <= 1'b1;
   end

   a_r1_dark_until_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_paging_en && !seen_wr) |-> !board_ce);

   a_r5_ramdis_masks: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_dis_n |-> !board_ce);

   a_r9_fixed_bank: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_paging_en |-> (bank_addr == cfg_board_page));

   a_r2_page_loads: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr |=> (!cfg_paging_en || cfg_common_en ||
                   bank_addr == $past(cpu_data[PAGE_W-1:0])));

   a_r6_top_is_page0: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_paging_en && cfg_common_en && (&cpu_addr[ADDR_W-1:ADDR_W-4]))
      |-> (bank_addr == '0));

endmodule

bind pgbank_sel pgbank_sel_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PAGE_W    (PAGE_W),
   .IO_ADDR_W (IO_ADDR_W),
   .PORT_ADDR (PORT_ADDR)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_addr       (cpu_addr),
   .cpu_data       (cpu_data),
   .iorq_n         (iorq_n),
   .wr_n           (wr_n),
   .ram_dis_n      (ram_dis_n),
   .cfg_board_page (cfg_board_page),
   .cfg_paging_en  (cfg_paging_en),
   .cfg_common_en  (cfg_common_en),
   .board_ce       (board_ce),
   .bank_addr      (bank_addr)
);

// File: tb/tb_pgbank_sel.sv
`timescale 1ns/1ps
module tb_pgbank_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        iorq_n = 1'b1;
   logic        mreq_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        ram_dis_n = 1'b1;
   logic [1:0]  cfg_board_page = 2'd2;
   logic        cfg_paging_en = 1'b1;
   logic        cfg_common_en = 1'b0;
   logic        cfg_common_8k = 1'b0;
   logic        board_ce;
   logic [1:0]  bank_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   pgbank_sel dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n), .ram_dis_n(ram_dis_n),
      .cfg_board_page(cfg_board_page), .cfg_paging_en(cfg_paging_en),
      .cfg_common_en(cfg_common_en), .cfg_common_8k(cfg_common_8k),
      .board_ce(board_ce), .bank_addr(bank_addr)
   );

   // Monitor: compare each expected item at the falling edge after it is driven
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({board_ce, bank_addr} !== e) begin
            errors++;
            $display("FAIL %s: ce=%0b bank=%0d expected ce=%0b bank=%0d",
                     t, board_ce, bank_addr, e[2], e[1:0]);
         end
      end
   end

   // Driver: present a memory access and queue its expected result
   task automatic access(input logic [15:0] a, input logic mreq, input logic rdis,
                         input logic ce, input logic [1:0] bank, input string tag);
      @(posedge clk); #1;
      cpu_addr  = a;
      mreq_n    = mreq;
      ram_dis_n = rdis;
      iorq_n    = 1'b1;
      wr_n      = 1'b1;
      exp_q.push_back({ce, bank});
      tag_q.push_back(tag);
   endtask

   task automatic io_write(input logic [7:0] port, input logic [7:0] d,
                           input logic iorq, input logic wr);
      @(posedge clk); #1;
      mreq_n   = 1'b1;
      cpu_addr = {8'h00, port};
      cpu_data = d;
      iorq_n   = iorq;
      wr_n     = wr;
      @(posedge clk); #1;
      iorq_n   = 1'b1;
      wr_n     = 1'b1;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic set_cfg(input logic [1:0] bp, input logic pg,
                          input logic cen, input logic c8);
      @(posedge clk); #1;
      cfg_board_page = bp;
      cfg_paging_en  = pg;
      cfg_common_en  = cen;
      cfg_common_8k  = c8;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: dark after reset
      access(16'h1234, 1'b0, 1'b1, 1'b0, 2'd0, "R1 no write yet low addr");
      access(16'hFFFF, 1'b0, 1'b1, 1'b0, 2'd0, "R1 no write yet top addr");

      // R3: writes that miss the port
      io_write(8'hFE, 8'h02, 1'b0, 1'b0);
      access(16'h1234, 1'b0, 1'b1, 1'b0, 2'd0, "R3 other port ignored");
      io_write(8'hFF, 8'h02, 1'b1, 1'b0);
      access(16'h1234, 1'b0, 1'b1, 1'b0, 2'd0, "R3 write without iorq ignored");

      // R2: upper data bits ignored, page 2 selected
      io_write(8'hFF, 8'hFE, 1'b0, 1'b0);
      access(16'h1234, 1'b0, 1'b1, 1'b1, 2'd2, "R2 page 2 loaded from 0xFE");
      access(16'hFFFF, 1'b0, 1'b1, 1'b1, 2'd2, "R8 top addr uses page, window off");
      access(16'h1234, 1'b1, 1'b1, 1'b0, 2'd2, "R4 no mreq no ce");
      access(16'h1234, 1'b0, 1'b0, 1'b0, 2'd2, "R5 ram disable masks");

      // R4: mismatched page
      io_write(8'hFF, 8'h01, 1'b0, 1'b0);
      access(16'h1234, 1'b0, 1'b1, 1'b0, 2'd1, "R4 page 1 vs board 2");

      // R2/R4: every page against matching board page
      for (int p = 0; p < 4; p++) begin
         set_cfg(p[1:0], 1'b1, 1'b0, 1'b0);
         io_write(8'hFF, {6'b101010, p[1:0]}, 1'b0, 1'b0);
         access(16'h8000, 1'b0, 1'b1, 1'b1, p[1:0], "R2 R4 page sweep match");
      end

      // Page 1 selected for the window checks
      io_write(8'hFF, 8'h01, 1'b0, 1'b0);

      // R6: 4K window
      set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
      access(16'hF000, 1'b0, 1'b1, 1'b0, 2'd0, "R6 4K window base to page 0");
      access(16'hEFFF, 1'b0, 1'b1, 1'b1, 2'd1, "R6 below 4K window keeps page");
      set_cfg(2'd0, 1'b1, 1'b1, 1'b0);
      access(16'hFFFF, 1'b0, 1'b1, 1'b1, 2'd0, "R6 4K window served by page 0 board");
      access(16'hEFFF, 1'b0, 1'b1, 1'b0, 2'd1, "R6 below window not page 0 board");

      // R7: 8K window
      set_cfg(2'd0, 1'b1, 1'b1, 1'b1);
      access(16'hE000, 1'b0, 1'b1, 1'b1, 2'd0, "R7 8K window base to page 0");
      access(16'hDFFF, 1'b0, 1'b1, 1'b0, 2'd1, "R7 below 8K window keeps page");
      access(16'hE000, 1'b0, 1'b0, 1'b0, 2'd0, "R5 ram disable in window");
      set_cfg(2'd1, 1'b1, 1'b1, 1'b1);
      access(16'hDFFF, 1'b0, 1'b1, 1'b1, 2'd1, "R7 below window on page 1 board");

      // R9: paging off, fixed bank, port ignored
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
      access(16'h4000, 1'b0, 1'b1, 1'b1, 2'd3, "R9 fixed bank answers");
      access(16'h4000, 1'b0, 1'b0, 1'b0, 2'd3, "R5 ram disable fixed bank");
      io_write(8'hFF, 8'h03, 1'b0, 1'b0);
      set_cfg(2'd1, 1'b1, 1'b0, 1'b0);
      access(16'h4000, 1'b0, 1'b1, 1'b1, 2'd1, "R9 port write while off ignored");

      // R1: reset again clears the page
      do_reset();
      access(16'h4000, 1'b0, 1'b1, 1'b0, 2'd0, "R1 dark after second reset");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL monitor: %0d items left, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule